// File: doc/BRIEF.md
# Runtime-Configurable CIC Decimator

This block filters and decimates one signed 15-bit sample stream (an I or a Q path) with a cascaded integrator-comb structure. The shape of the filter is chosen at run time. The host can pick the number of active sections (zero to three), the decimation ratio, the comb differential delay and a normalising right shift. An enable bit turns the filter off. When the filter is off, or when zero sections are chosen, the block passes its input straight to its output.

The host writes a new configuration into a staging register at any time. The staged values only take effect when a synchronising double-tag arrives. The double-tag is the tag input held high on two consecutive clock edges. At that moment every integrator, every comb history, the decimation phase and the output strobe are cleared. Because of this, no output sample ever mixes two configurations. Each accepted input sample enters the integrators. One in every R samples is passed through the combs, shifted, saturated to 15 bits and presented on the output with a one-cycle valid strobe.

Top module: `cic_decimator`

## Requirements
- R1: After reset the active configuration is pass-through: `outValid` is low during reset, and afterwards `outData`/`outValid` repeat `inData`/`inValid` one cycle later.
- R2: When the active enable bit is 0, or the active stage count is 0, the output is the input delayed by one cycle. Every valid sample appears, with no decimation, and the shift setting has no effect.
- R3: With ratio R (the 4-bit field `cfgRatio`; a written value of 0 is taken as 1), exactly one output is produced per R accepted samples. `outValid` rises for one cycle, in the cycle after the R-th sample is accepted. No output follows a cycle without an input sample.
- R4: With N active stages (the 2-bit field `cfgStages`, 1 to 3), the output equals N running sums of the input, sampled every R-th sample, followed by N differences with lag D. The result is then normalised as in R6.
- R5: The comb lag D (the 8-bit field `cfgDelay`, 1 to 255; a written value of 0 is taken as 1) is counted in decimated samples. Comb history from before the last commit reads as zero.
- R6: Normalisation is an arithmetic right shift by `cfgShift` (6 bits, 0 to 36; larger values are taken as 36). The result is then saturated to the range -16384 to 16383.
- R7: Writes through `cfgWrEn` only change the staging register. The running behaviour is unchanged until a commit.
- R8: A commit happens on the second of two consecutive cycles with `tagIn` high. A one-cycle tag does nothing, and a tag held longer commits only once. A commit loads all staged fields and clears all filter state. An input sample in the commit cycle is dropped, and `outValid` is low in the following cycle.
- R9: Internal sums are 51-bit two's complement and wrap freely. The output is still exact whenever the true filter result fits in 51 bits, including 3 stages, R=15, D=255 at full-scale input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Write the cfg fields into the staging register |
| cfgStages | input | 2 | Staged number of active sections (0 to 3) |
| cfgRatio | input | 4 | Staged decimation ratio (1 to 15, 0 taken as 1) |
| cfgDelay | input | 8 | Staged comb lag (1 to 255, 0 taken as 1) |
| cfgShift | input | 6 | Staged normalising right shift (0 to 36) |
| cfgEnable | input | 1 | Staged filter enable; 0 gives pass-through |
| tagIn | input | 1 | Synchronising tag; two consecutive high cycles commit |
| inValid | input | 1 | Input sample strobe |
| inData | input | 15 | Signed input sample |
| outValid | output | 1 | Output sample strobe |
| outData | output | 15 | Signed output sample |

## Verification
The bench builds the block with the package defaults: 15-bit samples, up to 3 sections, ratio up to 15 and comb lag up to 255. This gives 51-bit sums and three 255-entry comb histories. At these sizes a 12000-sample full-scale run at 3 stages, R=15 and D=255 wraps both the circular comb buffers and the 51-bit integrators. It still expects an exact settled output, so the worst-case growth budget is checked. Smaller setups exercise saturation at both rails, shift clamping, zero-field clamping, a commit in the middle of a stream and a held tag.

// File: rtl/cic_pkg.sv
package cic_pkg;
  parameter int IN_W      = 15;
  parameter int STAGE_MAX = 3;
  parameter int RATIO_MAX = 15;
  parameter int DELAY_MAX = 255;

  localparam int STG_W   = $clog2(STAGE_MAX + 1);
  localparam int RATIO_W = $clog2(RATIO_MAX + 1);
  localparam int DLY_W   = $clog2(DELAY_MAX + 1);
  localparam int PTR_W   = $clog2(DELAY_MAX);
  localparam int GROWTH  = STAGE_MAX * $clog2(RATIO_MAX * DELAY_MAX);
  localparam int ACC_W   = IN_W + GROWTH;
  localparam int SHIFT_W = $clog2(GROWTH + 1);

  typedef struct packed {
    logic [STG_W-1:0]   stages;
    logic [RATIO_W-1:0] ratio;
    logic [DLY_W-1:0]   delay;
    logic [SHIFT_W-1:0] shift;
    logic               enable;
  } cfg_t;

  typedef struct packed {
    logic             clear;
    logic             accept;
    logic             decimTick;
    logic             bypass;
    logic             primed;
    logic [PTR_W-1:0] wrPtr;
    logic [PTR_W-1:0] rdPtr;
  } ctl_t;
endpackage

// File: rtl/cic_ctrl.sv
module cic_ctrl
  import cic_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic cfgWrEn,
  input  cfg_t cfgIn,
  input  logic tagIn,
  input  logic inValid,
  output cfg_t actCfg,
  output ctl_t ctl
);
  localparam cfg_t CFG_RESET = '{stages: '0, ratio: RATIO_W'(1), delay: DLY_W'(1),
                                 shift: '0, enable: 1'b0};

  cfg_t             stageCfg;
  logic             tagD1, tagD2, commit;
  logic [RATIO_W-1:0] decimCnt;
  logic [PTR_W-1:0] wrPtr;
  logic [DLY_W-1:0] fillCnt;
  logic             bypass, accept, decimTick;
  logic [PTR_W:0]   wpExt, dlExt, rdExt;

  // Clamp out-of-range fields at write time so the active copy is always legal
  function automatic cfg_t sanitize(input cfg_t c);
    cfg_t r;
    r = c;
    if (c.ratio == '0) r.ratio = RATIO_W'(1);
    if (c.ratio > RATIO_W'(RATIO_MAX)) r.ratio = RATIO_W'(RATIO_MAX);
    if (c.delay == '0) r.delay = DLY_W'(1);
    if (c.delay > DLY_W'(DELAY_MAX)) r.delay = DLY_W'(DELAY_MAX);
    if (c.shift > SHIFT_W'(GROWTH)) r.shift = SHIFT_W'(GROWTH);
    return r;
  endfunction

  assign commit = tagIn & tagD1 & ~tagD2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageCfg <= CFG_RESET;
      actCfg   <= CFG_RESET;
      tagD1    <= 1'b0;
      tagD2    <= 1'b0;
    end else begin
      tagD1 <= tagIn;
      tagD2 <= tagD1;
      if (cfgWrEn) stageCfg <= sanitize(cfgIn);
      if (commit)  actCfg   <= stageCfg;
    end
  end

  always_comb begin
    bypass    = !actCfg.enable || (actCfg.stages == '0);
    accept    = inValid && !commit && !bypass;
    decimTick = accept && (decimCnt == actCfg.ratio - 1'b1);
    wpExt     = {1'b0, wrPtr};
    dlExt     = (PTR_W+1)'(actCfg.delay);
    if (wpExt >= dlExt) rdExt = wpExt - dlExt;
    else                rdExt = wpExt + (PTR_W+1)'(DELAY_MAX) - dlExt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decimCnt <= '0;
      wrPtr    <= '0;
      fillCnt  <= '0;
    end else if (commit) begin
      decimCnt <= '0;
      wrPtr    <= '0;
      fillCnt  <= '0;
    end else if (accept) begin
      if (decimTick) begin
        decimCnt <= '0;
        wrPtr    <= (wrPtr == PTR_W'(DELAY_MAX - 1)) ? '0 : wrPtr + 1'b1;
        if (fillCnt != DLY_W'(DELAY_MAX)) fillCnt <= fillCnt + 1'b1;
      end else begin
        decimCnt <= decimCnt + 1'b1;
      end
    end
  end

  always_comb begin
    ctl.clear     = commit;
    ctl.accept    = accept;
    ctl.decimTick = decimTick;
    ctl.bypass    = bypass;
    ctl.primed    = fillCnt >= actCfg.delay;
    ctl.wrPtr     = wrPtr;
    ctl.rdPtr     = rdExt[PTR_W-1:0];
  end
endmodule

// File: rtl/cic_datapath.sv
module cic_datapath
  import cic_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  ctl_t                   ctl,
  input  cfg_t                   actCfg,
  input  logic                   inValid,
  input  logic signed [IN_W-1:0] inData,
  output logic                   outValid,
  output logic signed [IN_W-1:0] outData
);
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((longint'(1) <<< (IN_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - 1;

  logic signed [ACC_W-1:0] acc     [STAGE_MAX];
  logic signed [ACC_W-1:0] intTap  [STAGE_MAX+1];
  logic signed [ACC_W-1:0] combTap [STAGE_MAX+1];
  logic [STAGE_MAX-1:0][ACC_W-1:0] delayed;
  logic signed [ACC_W-1:0] shifted;
  logic signed [IN_W-1:0]  normOut;

  // Integrator cascade: every section sees the current sample in the same cycle
  always_comb begin
    intTap[0] = {{GROWTH{inData[IN_W-1]}}, inData};
    for (int k = 0; k < STAGE_MAX; k++) intTap[k+1] = acc[k] + intTap[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < STAGE_MAX; k++) acc[k] <= '0;
    end else if (ctl.clear) begin
      for (int k = 0; k < STAGE_MAX; k++) acc[k] <= '0;
    end else if (ctl.accept) begin
      for (int k = 0; k < STAGE_MAX; k++) acc[k] <= intTap[k+1];
    end
  end

  // Comb cascade fed by the integrator tap that matches the active stage count
  always_comb begin
    combTap[0] = intTap[actCfg.stages];
    for (int k = 0; k < STAGE_MAX; k++)
      combTap[k+1] = combTap[k] - $signed(delayed[k]);
  end

  for (genvar g = 0; g < STAGE_MAX; g++) begin : g_comb
    logic signed [ACC_W-1:0] hist [DELAY_MAX];
    always_ff @(posedge clk) begin
      if (ctl.decimTick) hist[ctl.wrPtr] <= combTap[g];
    end
    assign delayed[g] = ctl.primed ? hist[ctl.rdPtr] : '0;
  end

  always_comb begin
    shifted = combTap[actCfg.stages] >>> actCfg.shift;
    if (shifted > SAT_HI)      normOut = IN_W'(SAT_HI);
    else if (shifted < SAT_LO) normOut = IN_W'(SAT_LO);
    else                       normOut = IN_W'(shifted);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else if (ctl.clear) begin
      outValid <= 1'b0;
    end else if (ctl.bypass) begin
      outValid <= inValid;
      if (inValid) outData <= inData;
    end else begin
      outValid <= ctl.decimTick;
      if (ctl.decimTick) outData <= normOut;
    end
  end
endmodule

// File: rtl/cic_decimator.sv
module cic_decimator
  import cic_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWrEn,
  input  logic [STG_W-1:0]       cfgStages,
  input  logic [RATIO_W-1:0]     cfgRatio,
  input  logic [DLY_W-1:0]       cfgDelay,
  input  logic [SHIFT_W-1:0]     cfgShift,
  input  logic                   cfgEnable,
  input  logic                   tagIn,
  input  logic                   inValid,
  input  logic signed [IN_W-1:0] inData,
  output logic                   outValid,
  output logic signed [IN_W-1:0] outData
);
  cfg_t cfgIn;
  cfg_t actCfg;
  ctl_t ctl;

  assign cfgIn = '{stages: cfgStages, ratio: cfgRatio, delay: cfgDelay,
                   shift: cfgShift, enable: cfgEnable};

  cic_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWrEn (cfgWrEn),
    .cfgIn   (cfgIn),
    .tagIn   (tagIn),
    .inValid (inValid),
    .actCfg  (actCfg),
    .ctl     (ctl)
  );

  cic_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .actCfg   (actCfg),
    .inValid  (inValid),
    .inData   (inData),
    .outValid (outValid),
    .outData  (outData)
  );
endmodule

// File: rtl/cic_decimator_chk.sv
module cic_decimator_chk
  import cic_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   tagIn,
  input logic                   inValid,
  input logic signed [IN_W-1:0] inData,
  input logic                   outValid,
  input logic signed [IN_W-1:0] outData,
  input logic                   bypass,
  input cfg_t                   actCfg
);
  logic tagQ1, tagQ2, commitSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagQ1 <= 1'b0;
      tagQ2 <= 1'b0;
    end else begin
      tagQ1 <= tagIn;
      tagQ2 <= tagQ1;
    end
  end

  assign commitSeen = tagIn && tagQ1 && !tagQ2;

  AST_COMMIT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    commitSeen |=> !outValid); // R8
  AST_PASS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (bypass && !commitSeen) |=> (outValid == $past(inValid))); // R2
  AST_PASS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (bypass && !commitSeen && inValid) |=> (outData == $past(inData))); // R2
  AST_NO_SAMPLE_NO_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (!bypass && !inValid) |=> !outValid); // R3
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (!bypass && actCfg.ratio > RATIO_W'(1) && outValid && !commitSeen) |=> !outValid); // R3
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !commitSeen |=> $stable(actCfg)); // R7
endmodule

bind cic_decimator cic_decimator_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tagIn    (tagIn),
  .inValid  (inValid),
  .inData   (inData),
  .outValid (outValid),
  .outData  (outData),
  .bypass   (ctl.bypass),
  .actCfg   (actCfg)
);

// File: tb/cic_decimator_tb.sv
module cic_decimator_tb;
  import cic_pkg::*;

  logic                   clk = 1'b0;
  logic                   rstN;
  logic                   cfgWrEn;
  logic [STG_W-1:0]       cfgStages;
  logic [RATIO_W-1:0]     cfgRatio;
  logic [DLY_W-1:0]       cfgDelay;
  logic [SHIFT_W-1:0]     cfgShift;
  logic                   cfgEnable;
  logic                   tagIn;
  logic                   inValid;
  logic signed [IN_W-1:0] inData;
  logic                   outValid;
  logic signed [IN_W-1:0] outData;

  int tests = 0;
  int fails = 0;
  longint mHist [3][16384];

  always #2 clk = ~clk;

  cic_decimator u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgStages(cfgStages),
    .cfgRatio(cfgRatio), .cfgDelay(cfgDelay), .cfgShift(cfgShift),
    .cfgEnable(cfgEnable), .tagIn(tagIn), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outData(outData)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint wrapAcc(input longint v);
    return (v <<< (64 - ACC_W)) >>> (64 - ACC_W);
  endfunction

  function automatic int stim(input int kind, input int i);
    case (kind)
      0:       return 16383;
      1:       return -16384;
      2:       return ((i * 37) % 2001) - 1000;
      default: return ((i * 7919 + 13) % 32768) - 16384;
    endcase
  endfunction

  function automatic int satOut(input longint v);
    if (v > 16383)  return 16383;
    if (v < -16384) return -16384;
    return int'(v);
  endfunction

  task automatic setCfg(input int stg, input int rat, input int dly, input int sh, input bit en);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgStages = STG_W'(stg); cfgRatio = RATIO_W'(rat); cfgDelay = DLY_W'(dly);
    cfgShift = SHIFT_W'(sh); cfgEnable = en;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // Two tag cycles; optionally drive a sample into the commit cycle, or keep the tag high
  task automatic commitTag(input bit dropSample, input bit hold);
    @(negedge clk);
    tagIn = 1'b1; inValid = 1'b0;
    @(negedge clk);
    if (dropSample) begin inValid = 1'b1; inData = -15'sd7777; end
    if (hold) return;
    @(negedge clk);
    tagIn = 1'b0; inValid = 1'b0;
    if (dropSample) check(outValid == 1'b0, "R8", "outValid after commit with sample", outValid, 0);
  endtask

  task automatic passTest(input string req);
    int errs = 0; longint fa = 0, fe = 0;
    bit pv = 0; int pd = 0;
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      if (i > 0 && (outValid !== pv || (pv && outData !== pd))) begin
        if (errs == 0) begin fa = outValid ? outData : -99999; fe = pv ? pd : -99999; end
        errs++;
      end
      if (i < 10) begin
        pv = (i % 3) != 1; pd = stim(3, i);
        inValid = pv; inData = IN_W'(pd);
      end else inValid = 1'b0;
    end
    check(errs == 0, req, "pass-through mismatches", fa, fe);
  endtask

  task automatic runFilter(input int nStg, input int rat, input int dly, input int sh,
                           input int kind, input int n, input int keepTag, input string req);
    longint integ [3]; longint v, d;
    int cnt = 0, m = 0, errs = 0, outs = 0, expD = 0;
    bit expV = 0; longint fa = 0, fe = 0;
    for (int k = 0; k < 3; k++) integ[k] = 0;
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      if (i > 0) begin
        if (outValid === 1'b1) outs++;
        if (outValid !== expV || (expV && outData !== expD)) begin
          if (errs == 0) begin fa = outValid ? outData : -99999; fe = expV ? expD : -99999; end
          errs++;
        end
      end
      if (i == n) begin inValid = 1'b0; tagIn = 1'b0; break; end
      begin
        int x;
        x = stim(kind, i);
        integ[0] = wrapAcc(integ[0] + x);
        integ[1] = wrapAcc(integ[1] + integ[0]);
        integ[2] = wrapAcc(integ[2] + integ[1]);
        v = integ[nStg-1];
        cnt++; expV = 0;
        if (cnt == rat) begin
          cnt = 0;
          for (int k = 0; k < nStg; k++) begin
            d = (m >= dly) ? mHist[k][m-dly] : 0;
            mHist[k][m] = v;
            v = wrapAcc(v - d);
          end
          expV = 1; expD = satOut(v >>> sh); m++;
        end
        inValid = 1'b1; inData = IN_W'(x); tagIn = (i < keepTag);
      end
    end
    check(errs == 0, req, "filtered sample mismatches", fa, fe);
    check(outs == n / rat, "R3", "output count", outs, n / rat);
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; cfgWrEn = 1'b0; cfgStages = '0; cfgRatio = '0; cfgDelay = '0;
    cfgShift = '0; cfgEnable = 1'b0; tagIn = 1'b0; inValid = 1'b0; inData = '0;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid in reset", outValid, 0);
    rstN = 1'b1;
    passTest("R1 reset pass-through");

    setCfg(3, 4, 5, 10, 0); commitTag(0, 0);
    passTest("R2 enable clear");
    setCfg(0, 4, 5, 10, 1); commitTag(0, 0);
    passTest("R2 zero stages");

    setCfg(1, 4, 3, 0, 1);
    passTest("R7 staged but not committed");
    @(negedge clk); tagIn = 1'b1;
    @(negedge clk); tagIn = 1'b0;
    passTest("R8 single tag ignored");
    commitTag(0, 0);
    runFilter(1, 4, 3, 0, 2, 200, 0, "R3 R5 one stage ramp");

    setCfg(2, 15, 7, 4, 1); commitTag(0, 0);
    runFilter(2, 15, 7, 4, 3, 600, 0, "R4 R6 two stage");

    setCfg(3, 4, 4, 0, 1); commitTag(0, 0);
    runFilter(3, 4, 4, 0, 0, 300, 0, "R6 saturate high");
    commitTag(0, 0);
    runFilter(3, 4, 4, 0, 1, 300, 0, "R6 saturate low");

    setCfg(1, 0, 0, 0, 1); commitTag(0, 0);
    runFilter(1, 1, 1, 0, 3, 50, 0, "R3 R5 zero fields clamped");

    setCfg(3, 15, 100, 63, 1); commitTag(0, 0);
    runFilter(3, 15, 100, 36, 0, 4800, 0, "R6 shift clamp");

    setCfg(1, 1, 1, 0, 1); commitTag(0, 0);
    runFilter(1, 1, 1, 0, 2, 20, 0, "R4 identity");
    setCfg(2, 3, 2, 1, 1); commitTag(1, 0);
    runFilter(2, 3, 2, 1, 2, 90, 0, "R8 state cleared on commit");

    setCfg(1, 2, 2, 0, 1); commitTag(0, 1);
    runFilter(1, 2, 2, 0, 3, 60, 2, "R8 held tag commits once");

    setCfg(3, 15, 255, 36, 1); commitTag(0, 0);
    runFilter(3, 15, 255, 36, 0, 12000, 0, "R9 R5 full depth wrap");

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule